// File: doc/BRIEF.md
# Multicycle 64-bit RISC Core with Per-Class Latency

This block is a non-pipelined processor core. It works on one instruction at a time and walks it through fetch, decode, execute, memory and write-back, one clock per step. Each instruction class stops after the last step it actually needs. A branch is finished after decode, a store after the memory step, and every other instruction after write-back. The supported set is a small 64-bit subset: register-register add, register-immediate add, 64-bit load, 64-bit store, branch-if-zero and branch-if-not-equal. Instructions use the standard 32-bit I-type and R-type field layout: opcode in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11, shift amount in 10:6, function code in 5:0, and the 16-bit immediate in 15:0.

Instruction memory and data memory are small internal word arrays. A loading port writes either array at any time; the core is normally held in reset while this happens. Two read-only observation ports return one general register and one data memory word. They let a bench inspect results. A retire pulse and a free-running cycle counter expose how long each instruction took.

Top module: `mc_core`

## Requirements
- R1: After reset the core starts in fetch with PC 0. Steps always follow the order fetch, decode, execute, memory, write-back, one clock each. The step after an instruction's final step is the fetch of the next instruction.
- R2: Fetch reads the instruction word at PC/4 and advances PC by 4.
- R3: Opcode 0x04 (branch if zero) tests only register rs against zero; the rt field is ignored. Opcode 0x05 (branch if not equal) compares rs with rt. Both branch types finish in 2 cycles. When the branch is taken, the new PC is PC+4 plus the sign-extended 16-bit offset shifted left by 2.
- R4: A store (opcode 0x3F) finishes in 4 cycles. It writes register rt to data word (rs + sign-extended imm) >> 3 and writes no register.
- R5: The register-register add (opcode 0x00, function 0x2C, shift field 0) writes rs+rt to rd. The immediate add (opcode 0x19) writes rs + sign-extended imm to rt. Each finishes in 5 cycles.
- R6: A load (opcode 0x37) writes data word (rs + sign-extended imm) >> 3 to rt and finishes in 5 cycles. The displacement may be negative.
- R7: Register 0 always reads as zero, and writes to it have no effect.
- R8: `retire` is high for exactly the one cycle of an instruction's final step. It is never high in two consecutive cycles.
- R9: `cycle_count` reads 0 in the first cycle after reset is released and increases by one every clock.
- R10: During reset `retire` is low. The loading port writes instruction memory when `ld_dmem` is 0 and data memory when it is 1, in both cases at word index `ld_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Loading port write strobe |
| ld_dmem | input | 1 | Loading port target: 0 instruction memory, 1 data memory |
| ld_addr | input | LAW | Loading port word index |
| ld_data | input | 64 | Loading port data (low 32 bits for instruction memory) |
| dbg_reg_addr | input | 5 | Register observation index |
| dbg_reg_data | output | 64 | Register observation value |
| dbg_mem_addr | input | DAW | Data memory observation word index |
| dbg_mem_data | output | 64 | Data memory observation value |
| retire | output | 1 | High during an instruction's final step |
| cycle_count | output | CNT_W | Clocks since reset release |

## Verification
The assertions assume three things about the inputs. The loading port is only used while reset is held. Programs stay inside the memory arrays. Every instruction word is a supported encoding or is tolerated as a five-cycle no-operation. The stimulus respects this: every program and the data preload are written under reset. Each program ends in a branch to itself, so after the checked sequence the core only repeats a two-cycle instruction that writes nothing. Register and memory results are read through the observation ports only after that point.

// File: rtl/mc_pkg.sv
package mc_pkg;
    parameter int XLEN = 64;
    parameter int ILEN = 32;
    parameter int NREG = 32;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_MEMORY,
        ST_WRBACK
    } step_e;

    typedef enum logic [2:0] {
        K_ADDR,
        K_ADDI,
        K_LOAD,
        K_STORE,
        K_BEQZ,
        K_BNE,
        K_OTHER
    } iclass_e;

    localparam logic [5:0] OP_SPECIAL = 6'h00;
    localparam logic [5:0] OP_BEQZ    = 6'h04;
    localparam logic [5:0] OP_BNE     = 6'h05;
    localparam logic [5:0] OP_ADDI    = 6'h19;
    localparam logic [5:0] OP_LOAD    = 6'h37;
    localparam logic [5:0] OP_STORE   = 6'h3F;
    localparam logic [5:0] FN_ADD     = 6'h2C;

    typedef struct packed {
        iclass_e         cls;
        logic [4:0]      rs;
        logic [4:0]      rt;
        logic [4:0]      dst;
        logic [XLEN-1:0] imm;
        logic            writes;
    } dec_t;
endpackage

// File: rtl/mc_decode.sv
module mc_decode
    import mc_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output dec_t            dec
);
    logic [5:0] opcode;
    logic [5:0] funct;
    logic [4:0] shamt;

    always_comb begin
        opcode     = instr[31:26];
        funct      = instr[5:0];
        shamt      = instr[10:6];
        dec.rs     = instr[25:21];
        dec.rt     = instr[20:16];
        dec.dst    = instr[20:16];
        dec.imm    = {{(XLEN-16){instr[15]}}, instr[15:0]};
        dec.writes = 1'b0;
        dec.cls    = K_OTHER;
        case (opcode)
            OP_SPECIAL: begin
                if (funct == FN_ADD && shamt == 5'd0) begin
                    dec.cls    = K_ADDR;
                    dec.dst    = instr[15:11];
                    dec.writes = 1'b1;
                end
            end
            OP_ADDI: begin
                dec.cls    = K_ADDI;
                dec.writes = 1'b1;
            end
            OP_LOAD: begin
                dec.cls    = K_LOAD;
                dec.writes = 1'b1;
            end
            OP_STORE: dec.cls = K_STORE;
            OP_BEQZ:  dec.cls = K_BEQZ;
            OP_BNE:   dec.cls = K_BNE;
            default:  dec.cls = K_OTHER;
        endcase
    end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int  DW   = 64,
    parameter int  NREG = 32,
    parameter int  NRD  = 3,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata
);
    logic [DW-1:0] regs [NREG-1:1];

    always_ff @(posedge clk) begin
        if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = (raddr[g] == '0) ? '0 : regs[raddr[g]];
    end
endmodule

// File: rtl/mc_mem.sv
module mc_mem #(
    parameter int  DW    = 64,
    parameter int  DEPTH = 32,
    parameter int  NRD   = 1,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata
);
    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = words[raddr[g]];
    end
endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int  IMEM_WORDS = 64,
    parameter int  DMEM_WORDS = 32,
    parameter int  CNT_W      = 32,
    localparam int IAW        = $clog2(IMEM_WORDS),
    localparam int DAW        = $clog2(DMEM_WORDS),
    localparam int LAW        = (IAW > DAW) ? IAW : DAW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic             ld_dmem,
    input  logic [LAW-1:0]   ld_addr,
    input  logic [XLEN-1:0]  ld_data,
    input  logic [4:0]       dbg_reg_addr,
    output logic [XLEN-1:0]  dbg_reg_data,
    input  logic [DAW-1:0]   dbg_mem_addr,
    output logic [XLEN-1:0]  dbg_mem_data,
    output logic             retire,
    output logic [CNT_W-1:0] cycle_count
);
    localparam int WBYTES = XLEN / 8;
    localparam int WSH    = $clog2(WBYTES);

    typedef struct packed {
        step_e            step;
        logic [XLEN-1:0]  pc;
        logic [ILEN-1:0]  ir;
        logic [XLEN-1:0]  opa;
        logic [XLEN-1:0]  opb;
        logic [XLEN-1:0]  imm;
        logic [XLEN-1:0]  alu;
        logic [XLEN-1:0]  mdr;
        logic [CNT_W-1:0] cyc;
    } core_t;

    core_t q, d;
    dec_t  dec;

    logic [ILEN-1:0]           im_rdata;
    logic [2:0][XLEN-1:0]      rf_rdata;
    logic [XLEN-1:0]           rs_data, rt_data;
    logic [1:0][XLEN-1:0]      dm_rdata;
    logic                      rf_we, dm_we, retire_c, br_taken;
    logic [DAW-1:0]            dm_idx;
    logic [XLEN-1:0]           rf_wdata;

    mc_decode u_dec (
        .instr (q.ir),
        .dec   (dec)
    );

    mc_mem #(.DW(ILEN), .DEPTH(IMEM_WORDS), .NRD(1)) u_imem (
        .clk   (clk),
        .we    (ld_en && !ld_dmem),
        .waddr (ld_addr[IAW-1:0]),
        .wdata (ld_data[ILEN-1:0]),
        .raddr (q.pc[IAW+1:2]),
        .rdata (im_rdata)
    );

    assign dm_idx = q.alu[DAW+WSH-1:WSH];

    mc_mem #(.DW(XLEN), .DEPTH(DMEM_WORDS), .NRD(2)) u_dmem (
        .clk   (clk),
        .we    ((ld_en && ld_dmem) || dm_we),
        .waddr ((ld_en && ld_dmem) ? ld_addr[DAW-1:0] : dm_idx),
        .wdata ((ld_en && ld_dmem) ? ld_data : q.opb),
        .raddr ({dbg_mem_addr, dm_idx}),
        .rdata (dm_rdata)
    );

    assign rf_wdata = (dec.cls == K_LOAD) ? q.mdr : q.alu;

    mc_regfile #(.DW(XLEN), .NREG(NREG), .NRD(3)) u_rf (
        .clk   (clk),
        .we    (rf_we),
        .waddr (dec.dst),
        .wdata (rf_wdata),
        .raddr ({dbg_reg_addr, dec.rt, dec.rs}),
        .rdata (rf_rdata)
    );

    assign rs_data      = rf_rdata[0];
    assign rt_data      = rf_rdata[1];
    assign dbg_reg_data = rf_rdata[2];
    assign dbg_mem_data = dm_rdata[1];

    always_comb begin
        d        = q;
        d.cyc    = q.cyc + 1'b1;
        rf_we    = 1'b0;
        dm_we    = 1'b0;
        retire_c = 1'b0;
        br_taken = 1'b0;
        case (q.step)
            ST_FETCH: begin
                d.ir   = im_rdata;
                d.pc   = q.pc + XLEN'(4);
                d.step = ST_DECODE;
            end
            ST_DECODE: begin
                d.opa = rs_data;
                d.opb = rt_data;
                d.imm = dec.imm;
                if (dec.cls == K_BEQZ || dec.cls == K_BNE) begin
                    br_taken = (dec.cls == K_BEQZ) ? (rs_data == '0)
                                                   : (rs_data != rt_data);
                    if (br_taken) begin
                        d.pc = q.pc + (dec.imm << 2);
                    end
                    retire_c = 1'b1;
                    d.step   = ST_FETCH;
                end else begin
                    d.step = ST_EXEC;
                end
            end
            ST_EXEC: begin
                d.alu  = q.opa + ((dec.cls == K_ADDR) ? q.opb : q.imm);
                d.step = ST_MEMORY;
            end
            ST_MEMORY: begin
                if (dec.cls == K_LOAD) begin
                    d.mdr = dm_rdata[0];
                end
                if (dec.cls == K_STORE) begin
                    dm_we    = 1'b1;
                    retire_c = 1'b1;
                    d.step   = ST_FETCH;
                end else begin
                    d.step = ST_WRBACK;
                end
            end
            ST_WRBACK: begin
                rf_we    = dec.writes;
                retire_c = 1'b1;
                d.step   = ST_FETCH;
            end
            default: d.step = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.step <= ST_FETCH;
        end else begin
            q <= d;
        end
    end

    assign retire      = retire_c && rst_n;
    assign cycle_count = q.cyc;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
    import mc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             retire,
    input logic [CNT_W-1:0] cycle_count,
    input step_e            step,
    input logic [XLEN-1:0]  pc,
    input logic [4:0]       dbg_reg_addr,
    input logic [XLEN-1:0]  dbg_reg_data
);
    // R1
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step == ST_FETCH |=> step == ST_DECODE);

    // R1
    decode_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step == ST_DECODE |=> (step == ST_FETCH || step == ST_EXEC));

    // R1
    exec_to_memory_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step == ST_EXEC |=> step == ST_MEMORY);

    // R2
    fetch_pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step == ST_FETCH |=> pc == $past(pc) + XLEN'(4));

    // R8
    retire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire);

    // R1
    retire_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> step == ST_FETCH);

    // R9
    cycle_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cycle_count == $past(cycle_count) + 1'b1);

    // R7
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_reg_addr == 5'd0 |-> dbg_reg_data == '0);
endmodule

bind mc_core mc_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .retire       (retire),
    .cycle_count  (cycle_count),
    .step         (q.step),
    .pc           (q.pc),
    .dbg_reg_addr (dbg_reg_addr),
    .dbg_reg_data (dbg_reg_data)
);

// File: tb/sim_mc_core.sv
`timescale 1ns/1ps
module sim_mc_core;
    localparam int LAW = 6;
    localparam int DAW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ld_en = 1'b0;
    logic            ld_dmem = 1'b0;
    logic [LAW-1:0]  ld_addr = '0;
    logic [63:0]     ld_data = '0;
    logic [4:0]      dbg_reg_addr = '0;
    logic [63:0]     dbg_reg_data;
    logic [DAW-1:0]  dbg_mem_addr = '0;
    logic [63:0]     dbg_mem_data;
    logic            retire;
    logic [31:0]     cycle_count;

    int n_cmp = 0;
    int n_bad = 0;
    int total_cycles = 0;

    always #2.5 clk = ~clk;

    mc_core u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_en        (ld_en),
        .ld_dmem      (ld_dmem),
        .ld_addr      (ld_addr),
        .ld_data      (ld_data),
        .dbg_reg_addr (dbg_reg_addr),
        .dbg_reg_data (dbg_reg_data),
        .dbg_mem_addr (dbg_mem_addr),
        .dbg_mem_data (dbg_mem_data),
        .retire       (retire),
        .cycle_count  (cycle_count)
    );

    always @(posedge clk) begin
        total_cycles++;
        if (total_cycles > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog expired: actual %0d cycles expected < 150000", total_cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_add(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd);
        return {6'h00, rs, rt, rd, 5'd0, 6'h2C};
    endfunction

    task automatic put(input logic sel, input int addr, input logic [63:0] data);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_dmem = sel;
        ld_addr = LAW'(addr);
        ld_data = data;
        @(negedge clk);
        ld_en   = 1'b0;
    endtask

    task automatic chk_reg(input logic [4:0] r, input logic [63:0] exp, input string tag);
        dbg_reg_addr = r;
        #1;
        check(dbg_reg_data == exp, tag, dbg_reg_data, exp);
    endtask

    task automatic run_case(input logic [15:0] x, input logic [15:0] y);
        logic [63:0] sx, sy, r2, r3;
        int exp_lat[16];
        int n, k, prev, guard, lat;
        bit prev_ret;
        string tag;
        sx = {{48{x[15]}}, x};
        sy = {{48{y[15]}}, y};
        r2 = sx + sy;
        r3 = sx + r2;

        rst_n = 1'b0;
        put(0, 0,  {32'd0, enc_i(6'h19, 0, 6, 16'd2)});
        put(0, 1,  {32'd0, enc_i(6'h19, 0, 1, x)});
        put(0, 2,  {32'd0, enc_i(6'h19, 1, 2, y)});
        put(0, 3,  {32'd0, enc_add(1, 2, 3)});
        put(0, 4,  {32'd0, enc_i(6'h3F, 0, 3, 16'd24)});
        put(0, 5,  {32'd0, enc_i(6'h37, 0, 4, 16'd24)});
        put(0, 6,  {32'd0, enc_i(6'h05, 1, 0, 16'd1)});
        put(0, 7,  {32'd0, enc_i(6'h19, 0, 6, 16'd1)});
        put(0, 8,  {32'd0, enc_i(6'h19, 0, 5, 16'd48)});
        put(0, 9,  {32'd0, enc_i(6'h37, 5, 7, 16'hFFE8)});
        put(0, 10, {32'd0, enc_i(6'h19, 0, 0, 16'd7)});
        put(0, 11, {32'd0, enc_i(6'h04, 1, 9, 16'd1)});
        put(0, 12, {32'd0, enc_i(6'h19, 0, 5, 16'd8)});
        put(0, 13, {32'd0, enc_i(6'h04, 0, 0, 16'hFFFF)});
        put(1, 3,  64'hDEAD_BEEF_0000_1111);

        // R10: reset state and preload visibility
        dbg_mem_addr = 5'd3;
        #1;
        check(retire == 1'b0, "R10 retire in reset", 64'(retire), 64'd0);
        check(cycle_count == 0, "R10 counter in reset", 64'(cycle_count), 64'd0);
        check(dbg_mem_data == 64'hDEAD_BEEF_0000_1111, "R10 data preload",
              dbg_mem_data, 64'hDEAD_BEEF_0000_1111);

        n = 0;
        exp_lat[n++] = 5; exp_lat[n++] = 5; exp_lat[n++] = 5; exp_lat[n++] = 5;
        exp_lat[n++] = 4; exp_lat[n++] = 5; exp_lat[n++] = 2;
        if (x == 16'd0) exp_lat[n++] = 5;
        exp_lat[n++] = 5; exp_lat[n++] = 5; exp_lat[n++] = 5; exp_lat[n++] = 2;
        if (x != 16'd0) exp_lat[n++] = 5;
        exp_lat[n++] = 2; exp_lat[n++] = 2;

        @(negedge clk);
        rst_n    = 1'b1;
        k        = 0;
        prev     = -1;
        guard    = 0;
        prev_ret = 1'b0;
        while (k < n && guard < 400) begin
            #1;
            if (retire) begin
                // R8: no back-to-back retire
                check(!prev_ret, "R8 consecutive retire", 64'd1, 64'd0);
                if (k == 0) begin
                    // R9: first 5-cycle instruction ends at counter value 4
                    check(cycle_count == 4, "R9 first retire count", 64'(cycle_count), 64'd4);
                end
                lat = int'(cycle_count) - prev;
                tag = (exp_lat[k] == 2) ? "R3 branch latency" :
                      (exp_lat[k] == 4) ? "R4 store latency"  : "R5 R6 latency";
                check(lat == exp_lat[k], tag, 64'(lat), 64'(exp_lat[k]));
                prev = int'(cycle_count);
                k++;
            end
            prev_ret = retire;
            @(negedge clk);
            guard++;
        end
        check(k == n, "R1 retire count", 64'(k), 64'(n));

        chk_reg(5'd1, sx, "R5 immediate add");
        chk_reg(5'd2, r2, "R5 immediate add with base");
        chk_reg(5'd3, r3, "R5 register add");
        chk_reg(5'd4, r3, "R6 load after store");
        chk_reg(5'd7, r3, "R6 negative displacement load");
        chk_reg(5'd0, 64'd0, "R7 register zero");
        chk_reg(5'd6, (x == 16'd0) ? 64'd1 : 64'd2, "R3 not-equal branch outcome");
        chk_reg(5'd5, (x == 16'd0) ? 64'd48 : 64'd8, "R3 zero branch outcome");
        #1;
        check(dbg_mem_data == r3, "R4 store data", dbg_mem_data, r3);
    endtask

    initial begin
        logic [15:0] xs[6];
        logic [15:0] ys[5];
        xs[0] = 16'h0000; xs[1] = 16'h0001; xs[2] = 16'hFFFF;
        xs[3] = 16'h7FFF; xs[4] = 16'h8000; xs[5] = 16'h1234;
        ys[0] = 16'h0000; ys[1] = 16'h0001; ys[2] = 16'hFFFF;
        ys[3] = 16'h7FFF; ys[4] = 16'h8000;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 5; j++) begin
                run_case(xs[i], ys[j]);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule